// File: doc/BRIEF.md
# Serial-to-Parallel Word Collector with Marker Completion and Parity Halt

This block gathers a one-bit serial stream into fixed-width parallel words. Each frame carries `WORD_W` data bits, most significant first, followed by a single even-parity bit, one bit per rising clock edge with no gaps between frames. The block does not count bit positions. A single set bit, the marker, is loaded at the low end of the shift path. Every incoming bit pushes it one place up, and the word is complete when the marker leaves the top of the data field.

When the parity bit agrees with the data, the word is copied to a registered output and a one-cycle ready strobe is raised. When it disagrees, an error flag is raised and the block freezes. It ignores the serial input and keeps its last good word until a synchronous reset clears it. A reset also throws away any partly collected frame, so the next bit after reset is treated as the first data bit of a new frame.

Top module: `mkd_deser_top`

## Requirements
- R1: While `rst` is high on a rising edge, `word_out`, `word_rdy` and `par_err` become 0 after that edge. The first `sdin` bit sampled after reset is released is taken as the first data bit of a new frame.
- R2: A frame is `WORD_W` (8) data bits followed by one parity bit, one bit per rising edge. The first data bit received appears at `word_out[WORD_W-1]` and the last at `word_out[0]`.
- R3: A frame is good when its data bits and its parity bit together contain an even number of ones.
- R4: After the edge that samples a good parity bit, `word_rdy` is 1 for exactly one cycle and `word_out` holds the new word during that cycle.
- R5: The edge right after a parity bit samples the first data bit of the next frame, so frames may follow back to back without reset.
- R6: After the edge that samples a bad parity bit, `par_err` is 1, `word_rdy` stays 0 and `word_out` keeps its previous value.
- R7: While `par_err` is 1, the block stays halted. `par_err` stays 1, `word_rdy` stays 0, `word_out` does not change, and `sdin` has no effect until reset.
- R8: A reset in the middle of a frame discards the partial frame, and a reset while halted clears `par_err`. A full frame sent after either reset is collected correctly.
- R9: Between completions, `word_out` holds the last good word and `word_rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial data bit, sampled on each rising edge |
| word_out | output | WORD_W | Last good parallel word, registered |
| word_rdy | output | 1 | One-cycle strobe marking a new good word |
| par_err | output | 1 | Sticky parity-error flag; the block is halted while high |

## Verification
A marker that is lost, duplicated or misplaced changes the frame length. The strobe then appears one or more edges early or late relative to the parity bit, and the bits in `word_out` come out shifted. The bench catches this on the first frame after the fault by sampling exactly one edge after each parity bit. A wrong parity sense or a halt that does not stick shows as a strobe where `par_err` was expected, or as a changed `word_out` in the frame sent while halted. The bench checks both within the frame that follows the fault.

// File: rtl/mkd_pkg.sv
package mkd_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } run_state_t;
endpackage

// File: rtl/mkd_shift_path.sv
module mkd_shift_path #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sdin,
  output logic [WORD_W-1:0] data,
  output logic              full
);
  localparam logic [WORD_W-1:0] MARKER = {{(WORD_W-1){1'b0}}, 1'b1};

  // The marker sits below the data bits. When it reaches the carry slot
  // (full), the data field holds a complete word.
  always_ff @(posedge clk) begin
    if (rst || (run && full)) begin
      data <= MARKER;
      full <= 1'b0;
    end else if (run) begin
      {full, data} <= {data, sdin};
    end
  end

  // R5: full lasts one cycle, because the parity edge reloads the marker.
  assert_full_single_R5: assert property (@(posedge clk) disable iff (rst)
    full |=> !full);

  // R2: while a word is incomplete, the marker is still inside the data field.
  assert_marker_present_R2: assert property (@(posedge clk) disable iff (rst)
    !full |-> (data != '0));
endmodule

// File: rtl/mkd_parity_chk.sv
module mkd_parity_chk #(
  parameter int unsigned WORD_W = 8
) (
  input  logic [WORD_W-1:0] data,
  input  logic              pbit,
  output logic              good
);
  logic [WORD_W:0] acc;

  assign acc[0] = pbit;
  for (genvar i = 0; i < WORD_W; i++) begin : g_xor
    assign acc[i+1] = acc[i] ^ data[i];
  end

  // Even parity: the XOR over all data bits and the parity bit is 0.
  assign good = ~acc[WORD_W];
endmodule

// File: rtl/mkd_out_stage.sv
module mkd_out_stage
  import mkd_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              check,
  input  logic              good,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] word_out,
  output logic              word_rdy,
  output logic              par_err
);
  run_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      word_out <= '0;
      word_rdy <= 1'b0;
    end else begin
      word_rdy <= 1'b0;
      if (state == ST_RUN && check) begin
        if (good) begin
          word_out <= data;
          word_rdy <= 1'b1;
        end else begin
          state <= ST_HALT;
        end
      end
    end
  end

  assign par_err = (state == ST_HALT);

  // R4: the strobe is a single-cycle pulse.
  assert_rdy_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    word_rdy |=> !word_rdy);

  // R4: a strobe only follows a cycle in which the word was complete.
  assert_rdy_after_check_R4: assert property (@(posedge clk) disable iff (rst)
    word_rdy |-> $past(check));

  // R6: the error flag and the strobe are never high together.
  assert_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(word_rdy && par_err));

  // R7: the error flag is sticky until reset.
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  // R7: the output word is frozen while halted.
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    par_err |=> $stable(word_out));
endmodule

// File: rtl/mkd_deser_top.sv
module mkd_deser_top #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdin,
  output logic [WORD_W-1:0] word_out,
  output logic              word_rdy,
  output logic              par_err
);
  logic [WORD_W-1:0] sh_data;
  logic              sh_full;
  logic              par_good;
  logic              run;

  assign run = ~par_err;

  mkd_shift_path #(.WORD_W(WORD_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sdin (sdin),
    .data (sh_data),
    .full (sh_full)
  );

  mkd_parity_chk #(.WORD_W(WORD_W)) u_par (
    .data (sh_data),
    .pbit (sdin),
    .good (par_good)
  );

  mkd_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .check    (sh_full),
    .good     (par_good),
    .data     (sh_data),
    .word_out (word_out),
    .word_rdy (word_rdy),
    .par_err  (par_err)
  );
endmodule

// File: tb/sim_mkd_deser_top.sv
module sim_mkd_deser_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sdin = 1'b0;
  logic [W-1:0] word_out;
  logic         word_rdy;
  logic         par_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [W-1:0] exp_word = '0;
  logic         exp_err = 1'b0;

  always #10 clk = ~clk;

  mkd_deser_top #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .sdin(sdin),
    .word_out(word_out), .word_rdy(word_rdy), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic even_par(input logic [W-1:0] d);
    return ^d;
  endfunction

  // Called at a falling edge: drive a bit, then wait for the next falling edge.
  task automatic send_bit(input logic b);
    sdin = b;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sdin = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_word = '0;
    exp_err = 1'b0;
    chk("R1 word_out", 32'(word_out), 0);
    chk("R1 word_rdy", 32'(word_rdy), 0);
    chk("R1 par_err", 32'(par_err), 0);
  endtask

  task automatic send_frame(input logic [W-1:0] d, input logic corrupt);
    logic p;
    p = even_par(d) ^ corrupt;
    for (int i = W - 1; i >= 0; i--) begin
      send_bit(d[i]);
      if (i == W - 2) begin
        chk("R9 rdy low mid-frame", 32'(word_rdy), 0);
        chk("R9 word held mid-frame", 32'(word_out), 32'(exp_word));
      end
    end
    send_bit(p);
    if (exp_err) begin
      chk("R7 rdy while halted", 32'(word_rdy), 0);
      chk("R7 err sticky", 32'(par_err), 1);
      chk("R7 word frozen", 32'(word_out), 32'(exp_word));
    end else if (!corrupt) begin
      exp_word = d;
      chk("R4 rdy strobe", 32'(word_rdy), 1);
      chk("R2 R3 word", 32'(word_out), 32'(d));
      chk("R3 no err", 32'(par_err), 0);
    end else begin
      exp_err = 1'b1;
      chk("R6 err set", 32'(par_err), 1);
      chk("R6 no rdy", 32'(word_rdy), 0);
      chk("R6 word kept", 32'(word_out), 32'(exp_word));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    @(negedge clk);
    do_reset();

    // R2: bit order, with directed patterns
    send_frame(8'h80, 1'b0);
    send_frame(8'h01, 1'b0);
    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b0);
    send_frame(8'hA5, 1'b0);
    // R5: the frames above ran back to back; check that the strobe dropped
    send_bit(1'b0);
    chk("R4 R5 strobe single cycle", 32'(word_rdy), 0);
    do_reset();

    // R8: reset mid-frame discards the partial bits
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_reset();
    send_frame(8'h3C, 1'b0);

    // R6, R7: a bad frame halts; a later good frame is ignored
    send_frame(8'h5A, 1'b1);
    send_frame(8'hC3, 1'b0);
    send_frame(8'h0F, 1'b1);
    do_reset();
    chk("R8 err cleared", 32'(par_err), 0);
    send_frame(8'h96, 1'b0);

    // random frames with occasional corruption
    for (int n = 0; n < 60; n++) begin
      logic [W-1:0] d;
      logic c;
      d = 8'($urandom);
      c = (($urandom % 6) == 0);
      send_frame(d, c);
      if (exp_err) begin
        send_frame(8'($urandom), 1'($urandom));
        do_reset();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule